// File: doc/BRIEF.md
# UART Baud Rate Generator

This block derives the bit timing for a UART from the system clock. A 12-bit divisor, loaded over a byte-wide write port as an upper and a lower byte, drives a reloading down-counter. Each time the counter sits at zero the block emits a one-cycle receive tick, so the tick rate is fclk/(DIV+1). The receiver's sampling logic consumes this tick directly.

A post-divider counts ticks and produces a one-cycle transmitter bit-enable every 16, 8 or 2 ticks. The count depends on the operating mode: asynchronous, asynchronous at double speed, or synchronous master. The block reports the active oversampling ratio as a code, so the receiver can size its phase counter. In synchronous master mode it also drives a 50% duty clock for an external serial clock pin.

Top module: `uart_baud_gen`

## Requirements
- R1: Outside reset, the counter decrements once per clock while nonzero. In the cycle after it reads zero it holds the divisor, so with a fixed divisor DIV, `rx_tick` pulses for one cycle every DIV+1 cycles.
- R2: A write with `wr_sel`=0 loads {staged upper bits, `wr_data`} into both the divisor and the counter at that clock edge, restarting the tick period at once.
- R3: A write with `wr_sel`=1 stores only `wr_data[3:0]` in a staging register. The active divisor and the tick timing do not change until the next lower-byte write.
- R4: With a divisor of 0, `rx_tick` is high on every clock cycle.
- R5: `tx_bit_en` is high only together with `rx_tick`, once per 16 ticks when asynchronous, per 8 ticks when asynchronous at double speed, and per 2 ticks in synchronous mode.
- R6: When `sync_mode`=1, `dbl_speed` has no effect on any output.
- R7: `rx_phases` encodes the ratio as 2'b00 for 16, 2'b01 for 8 and 2'b10 for 2.
- R8: When `sync_mode`=1, `xck` toggles on the edge after every tick. When `sync_mode`=0, `xck` goes low on the next edge and stays low.
- R9: A change of the effective ratio clears the tick count of the post-divider at the next edge and suppresses `tx_bit_en` in the cycle of the change. The next bit-enable then comes on the N-th following tick.
- R10: `rst_n` low clears the counter, divisor, staging register, post-divider and `xck` at once and forces `rx_tick` and `tx_bit_en` low. Operation resumes on the second rising clock edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | 1 selects the upper divisor bits, 0 the lower byte |
| wr_data | input | 8 | Write data |
| sync_mode | input | 1 | 1 selects synchronous master operation |
| dbl_speed | input | 1 | Double-speed request for asynchronous operation |
| rx_tick | output | 1 | Undivided tick for the receiver |
| tx_bit_en | output | 1 | One-cycle transmitter bit enable |
| xck | output | 1 | Synchronous master serial clock |
| rx_phases | output | 2 | Oversampling ratio code |

## Verification
The bench goes after a divisor of zero, where a counter that skips its reload slot would drop ticks. It also tests a lower-byte write in the middle of a count, where a design that waited for zero would deliver a late tick. An upper-byte write without a following lower-byte write checks for a design that applied the byte early and shifted the tick period. Mode changes in the middle of a count, double speed asserted in synchronous mode, and the full 4095 divisor look for a stale post-divider phase, a wrong ratio, a stuck `xck` and a truncated counter, each of which shows up as a misplaced pulse in the per-cycle comparison.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  typedef enum logic [1:0] {
    OVS_16 = 2'b00,
    OVS_8  = 2'b01,
    OVS_2  = 2'b10
  } ovs_mode_e;

  function automatic logic [4:0] ovs_ratio(input ovs_mode_e m);
    case (m)
      OVS_8:   ovs_ratio = 5'd8;
      OVS_2:   ovs_ratio = 5'd2;
      default: ovs_ratio = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]  hi_q, hi_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ld_lo, ld_hi;

  assign ld_lo = wr_en & ~wr_sel;
  assign ld_hi = wr_en &  wr_sel;

  always_comb begin
    hi_d  = hi_q;
    div_d = div_q;
    cnt_d = cnt_q;
    if (ld_hi) hi_d = wr_data[HI_W-1:0];
    if (ld_lo) begin
      div_d = {hi_q, wr_data};
      cnt_d = {hi_q, wr_data};
    end else if (cnt_q == '0) begin
      cnt_d = div_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q  <= '0;
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      hi_q  <= hi_d;
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick = rst_sync_n & (cnt_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld_lo && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R1
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld_lo && tick) |=> cnt_q == $past(div_q)); // R1
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_lo |=> (cnt_q == {$past(hi_q), $past(wr_data)}) && (div_q == cnt_q)); // R2
  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_hi |=> $stable(div_q)); // R3
endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv
  import uart_baud_pkg::*;
#(
  parameter int PD_W = 4
) (
  input  logic      clk,
  input  logic      rst_sync_n,
  input  logic      tick,
  input  ovs_mode_e mode,
  output logic      bit_en
);
  ovs_mode_e        mode_q;
  logic [PD_W-1:0]  pc_q, pc_d;
  logic [PD_W-1:0]  last;
  logic             chg;

  assign last = PD_W'(ovs_ratio(mode) - 5'd1);
  assign chg  = (mode != mode_q);

  always_comb begin
    pc_d = pc_q;
    if (chg)       pc_d = '0;
    else if (tick) pc_d = (pc_q == last) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      mode_q <= OVS_16;
    end else begin
      pc_q   <= pc_d;
      mode_q <= mode;
    end
  end

  assign bit_en = tick & ~chg & (pc_q == last);

  AST_EN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_en |-> tick); // R5
  AST_PC_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chg |-> pc_q <= last); // R5
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chg |=> pc_q == '0); // R9
  AST_NO_EN_ON_CHG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chg |-> !bit_en); // R9
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int BYTE_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  output logic              rx_tick,
  output logic              tx_bit_en,
  output logic              xck,
  output logic [1:0]        rx_phases
);
  localparam int PD_W = $clog2(16);

  logic      rst_sync_n;
  ovs_mode_e mode;
  logic      xck_q, xck_d;

  always_comb begin
    if (sync_mode)      mode = OVS_2;
    else if (dbl_speed) mode = OVS_8;
    else                mode = OVS_16;
  end

  baud_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  baud_divider #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_div (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .tick       (rx_tick)
  );

  baud_postdiv #(.PD_W(PD_W)) u_pd (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .tick       (rx_tick),
    .mode       (mode),
    .bit_en     (tx_bit_en)
  );

  always_comb begin
    xck_d = xck_q;
    if (!sync_mode)   xck_d = 1'b0;
    else if (rx_tick) xck_d = ~xck_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) xck_q <= 1'b0;
    else             xck_q <= xck_d;
  end

  assign xck       = xck_q;
  assign rx_phases = mode;

  AST_XCK_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sync_mode && !rx_tick) |=> $stable(xck)); // R8
  AST_XCK_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sync_mode |=> !xck); // R8
  AST_SYNC_RATIO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sync_mode |-> rx_phases == 2'b10); // R6
endmodule

// File: tb/sim_uart_baud_gen.sv
`timescale 1ns/100ps
module sim_uart_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sync_mode = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       rx_tick, tx_bit_en, xck;
  logic [1:0] rx_phases;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sync_mode(sync_mode), .dbl_speed(dbl_speed),
    .rx_tick(rx_tick), .tx_bit_en(tx_bit_en), .xck(xck), .rx_phases(rx_phases)
  );

  // behavioural reference
  int m_s1, m_s2, m_cnt, m_div, m_hi, m_pc, m_code, m_xck;

  function automatic int code_of(bit s, bit d);
    return s ? 2 : (d ? 1 : 0);
  endfunction
  function automatic int ratio_of(int c);
    return (c == 2) ? 2 : ((c == 1) ? 8 : 16);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_div = 0; m_hi = 0;
      m_pc = 0; m_code = 0; m_xck = 0;
    end else begin
      int ok, c, tk;
      ok = m_s2; m_s2 = m_s1; m_s1 = 1;
      if (ok != 0) begin
        c  = code_of(sync_mode, dbl_speed);
        tk = (m_cnt == 0);
        if (wr_en && wr_sel) m_hi = wr_data % 16;
        if (wr_en && !wr_sel) begin
          m_div = m_hi * 256 + wr_data;
          m_cnt = m_div;
        end else if (tk != 0) m_cnt = m_div;
        else m_cnt = m_cnt - 1;
        if (c != m_code) m_pc = 0;
        else if (tk != 0) m_pc = (m_pc + 1) % ratio_of(c);
        m_code = c;
        if (!sync_mode) m_xck = 0;
        else if (tk != 0) m_xck = 1 - m_xck;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int c, e_tick, e_en;
    c = code_of(sync_mode, dbl_speed);
    e_tick = (m_s2 != 0) && (m_cnt == 0);
    e_en = e_tick && (c == m_code) && (m_pc == ratio_of(c) - 1);
    chk("R1 rx_tick", int'(rx_tick), e_tick);
    chk("R5 tx_bit_en", int'(tx_bit_en), e_en);
    chk("R8 xck", int'(xck), m_xck);
    chk("R7 rx_phases", int'(rx_phases), c);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // measures cycles between two consecutive receive ticks
  task automatic tick_gap(string tag, int exp);
    int g;
    @(negedge clk);
    while (!rx_tick) @(negedge clk);
    g = 0;
    do begin @(negedge clk); g++; end while (!rx_tick);
    chk(tag, g, exp);
  endtask

  initial begin
    // R10: reset state
    cyc(4);
    @(negedge clk);
    chk("R10 reset rx_tick", int'(rx_tick), 0);
    chk("R10 reset tx_bit_en", int'(tx_bit_en), 0);
    chk("R10 reset xck", int'(xck), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    // R10 / R4: divisor 0 after reset, tick every cycle once released
    cyc(40);
    tick_gap("R4 gap with divisor 0", 1);
    // R5 / R9: double speed
    dbl_speed = 1'b1; cyc(40);
    // R6 / R8: synchronous master with and without double speed
    sync_mode = 1'b1; cyc(40);
    dbl_speed = 1'b0; cyc(40);
    // R3: upper bits staged only, upper nibble of data ignored
    wr(1'b1, 8'hF2); cyc(30);
    tick_gap("R3 staged upper byte leaves period", 1);
    // R2: lower byte applies 0x203
    sync_mode = 1'b0; dbl_speed = 1'b1;
    wr(1'b0, 8'h03);
    tick_gap("R2 period after lower write", 516);
    cyc(9000);
    // R1: small divisor in sync mode
    sync_mode = 1'b1;
    wr(1'b1, 8'h00); wr(1'b0, 8'h03);
    tick_gap("R1 period divisor 3", 4);
    cyc(100);
    // R2: lower write mid-count reloads at once
    wr(1'b0, 8'h07); cyc(3);
    wr(1'b0, 8'h05); cyc(2);
    tick_gap("R2 period divisor 5", 6);
    cyc(50);
    // R9: mode changes mid-count
    sync_mode = 1'b0; cyc(13);
    dbl_speed = 1'b1; cyc(21);
    dbl_speed = 1'b0; cyc(7);
    sync_mode = 1'b1; dbl_speed = 1'b1; cyc(30);
    sync_mode = 1'b0; cyc(300);
    // R1: full-scale divisor
    sync_mode = 1'b1; dbl_speed = 1'b0;
    wr(1'b1, 8'h0F); wr(1'b0, 8'hFF);
    tick_gap("R1 period divisor 4095", 4096);
    cyc(9000);
    // R10: asynchronous reset in the middle of a count
    cyc(17); #0.5; rst_n = 1'b0; #0.5;
    chk("R10 async clear xck", int'(xck), 0);
    chk("R10 async clear tick", int'(rx_tick), 0);
    cyc(3); rst_n = 1'b1;
    cyc(2);
    tick_gap("R10 divisor cleared by reset", 1);
    cyc(20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule